// File: doc/BRIEF.md
# Power Domain Switch Sequencer

This block governs one switchable power domain. Software owns a single collapse bit in a control word. Setting the bit asks for the domain to be shut down. Clearing it asks for power to be restored. The block turns that request into an ordered, timed sequence on three outputs: the power-switch enable, the isolation clamp and the domain reset.

A status word sits one word above the control word. It carries two completion flags, one for each direction, and a live bit that reports whether the domain is powered. Software writes the request and then polls the matching completion flag.

Each transition is bounded. The settle interval and the step interval between output changes are parameters. The whole sequence must fit inside a 1500 us window at the configured clock rate.

Top module: `pwr_dom_seq`

## Requirements
- R1: After synchronous reset, the block is in these states:
  - collapse bit = 1;
  - `sw_en` = 0, `iso_en` = 1, `dom_rst` = 1;
  - status reads 32'h0000_8000, meaning the down-done flag is set and the up-done flag and powered bit are clear.
- R2: The control word is at byte offset 0, and only its bit 0 is stored (the collapse bit). It reads back as {31'b0, collapse}. A write updates the collapse bit at the write edge.
- R3: The status word is at byte offset 0x4:
  - bit 15 is down-done, bit 16 is up-done, bit 31 is powered, and every other bit reads 0;
  - writes to the status word have no effect;
  - every other word offset reads 0 and ignores writes;
  - address bits [1:0] are ignored.
- R4: Power-up starts on the first edge after a write leaves the collapse bit at 0 while the domain is off. Call that edge E. The outputs then change as follows:
  - `sw_en` rises at E;
  - `iso_en` falls and the powered bit sets at E+SETTLE_CYC;
  - `dom_rst` falls and up-done sets at E+SETTLE_CYC+STEP_CYC.
- R5: Power-down starts on the first edge after the collapse bit is 1 while the domain is on. Call that edge E. The outputs then change as follows:
  - `dom_rst` rises at E;
  - `iso_en` rises at E+STEP_CYC;
  - `sw_en` falls, the powered bit clears and down-done sets at E+2*STEP_CYC.
- R6: The completion flags are cleared as follows:
  - a control write of 1 clears up-done at the write edge;
  - a control write of 0 clears down-done at the write edge;
  - starting a sequence clears the opposite flag;
  - when a clearing write falls on the same edge as a completion, the clear wins;
  - the two flags are never both set.
- R7: A request that arrives during a sequence does not cut it short. The running sequence completes, and the opposite sequence starts on the next edge. A write that repeats the current request starts nothing.
- R8: Every transition completes within LIMIT_US microseconds at CLK_MHZ.
- R9: Isolation is asserted whenever the switch is open, and the domain reset is asserted whenever isolation is asserted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| addr | input | ADDR_W | Byte address of the register access |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data for `addr`, combinational |
| sw_en | output | 1 | Domain power-switch enable |
| iso_en | output | 1 | Isolation clamp enable |
| dom_rst | output | 1 | Domain reset, active high |

## Verification
Two events can land on the same edge: a control write that clears a completion flag, and the sequencer setting the opposite flag as it finishes. The bench issues a power-up request, waits exactly SETTLE_CYC+STEP_CYC cycles and then writes a collapse request, so that the write edge is the completion edge. The reference model then expects up-done to stay 0 and a power-down to begin on the following edge. The bench also reverses the request partway through a sequence and compares every output and the read data on every cycle.

// File: rtl/pds_pkg.sv
package pds_pkg;

    localparam int REG_W       = 32;
    localparam int COLLAPSE_B  = 0;
    localparam int DN_DONE_B   = 15;
    localparam int UP_DONE_B   = 16;
    localparam int PWR_ON_B    = 31;
    localparam int WORD_CTRL   = 0;
    localparam int WORD_STAT   = 1;

    typedef enum logic [2:0] {
        PS_OFF,
        PS_UP_SETTLE,
        PS_UP_ISO,
        PS_ON,
        PS_DN_RST,
        PS_DN_ISO
    } pds_state_e;

    // drive bundle towards the domain
    typedef struct packed {
        logic sw;
        logic iso;
        logic rst;
    } pds_drive_t;

    typedef struct packed {
        logic pwr_on;
        logic up_done;
        logic dn_done;
    } pds_status_t;

    // decoded control write
    typedef struct packed {
        logic wr;
        logic val;
    } pds_req_t;

    function automatic logic [REG_W-1:0] pack_status(input pds_status_t s);
        logic [REG_W-1:0] w;
        w            = '0;
        w[DN_DONE_B] = s.dn_done;
        w[UP_DONE_B] = s.up_done;
        w[PWR_ON_B]  = s.pwr_on;
        return w;
    endfunction

    function automatic logic [REG_W-1:0] pack_ctrl(input logic collapse);
        logic [REG_W-1:0] w;
        w             = '0;
        w[COLLAPSE_B] = collapse;
        return w;
    endfunction

    function automatic bit is_steady(input pds_state_e s);
        return (s == PS_OFF) || (s == PS_ON);
    endfunction

endpackage

// File: rtl/pds_regs.sv
module pds_regs
    import pds_pkg::*;
#(
    parameter int ADDR_W = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [REG_W-1:0]  wdata,
    input  pds_status_t       status,
    output logic              collapse,
    output pds_req_t          req,
    output logic [REG_W-1:0]  rdata
);
    localparam int WIDX_W = ADDR_W - 2;

    logic [WIDX_W-1:0] widx;
    logic              ctrl_hit;
    logic              unused_bits;

    assign widx        = addr[ADDR_W-1:2];
    assign ctrl_hit    = (widx == WIDX_W'(WORD_CTRL));
    assign unused_bits = ^{addr[1:0], wdata[REG_W-1:1]};

    assign req.wr  = wr_en && ctrl_hit;
    assign req.val = wdata[COLLAPSE_B];

    always_ff @(posedge clk) begin
        if (rst) begin
            collapse <= 1'b1;
        end else if (req.wr) begin
            collapse <= req.val;
        end
    end

    always_comb begin
        if (ctrl_hit) begin
            rdata = pack_ctrl(collapse);
        end else if (widx == WIDX_W'(WORD_STAT)) begin
            rdata = pack_status(status);
        end else begin
            rdata = '0;
        end
    end

    AST_CTRL_HOLD: assert property (@(posedge clk) disable iff (rst)
        !(wr_en && ctrl_hit) |=> $stable(collapse)); // R2

endmodule

// File: rtl/pds_timer.sv
module pds_timer #(
    parameter int W = 4
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         load,
    input  logic [W-1:0] load_val,
    output logic         zero
);
    logic [W-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt <= '0;
        end else if (load) begin
            cnt <= load_val;
        end else if (cnt != '0) begin
            cnt <= cnt - 1'b1;
        end
    end

    assign zero = (cnt == '0);

endmodule

// File: rtl/pds_fsm.sv
module pds_fsm
    import pds_pkg::*;
#(
    parameter int SETTLE_CYC = 16,
    parameter int STEP_CYC   = 4,
    parameter int LIMIT_CYC  = 75000,
    parameter int TMR_W      = 5
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             collapse,
    input  pds_req_t         req,
    input  logic             tmr_zero,
    output logic             tmr_load,
    output logic [TMR_W-1:0] tmr_val,
    output pds_drive_t       drv,
    output pds_status_t      status
);
    localparam int LIM_W = $clog2(LIMIT_CYC + 1);

    pds_state_e state;

    always_comb begin
        tmr_load = 1'b0;
        tmr_val  = TMR_W'(STEP_CYC - 1);
        unique case (state)
            PS_OFF: if (!collapse) begin
                tmr_load = 1'b1;
                tmr_val  = TMR_W'(SETTLE_CYC - 1);
            end
            PS_UP_SETTLE: tmr_load = tmr_zero;
            PS_ON:        tmr_load = collapse;
            PS_DN_RST:    tmr_load = tmr_zero;
            default:      tmr_load = 1'b0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state          <= PS_OFF;
            drv            <= '{sw: 1'b0, iso: 1'b1, rst: 1'b1};
            status         <= '{pwr_on: 1'b0, up_done: 1'b0, dn_done: 1'b1};
        end else begin
            unique case (state)
                PS_OFF: if (!collapse) begin
                    state          <= PS_UP_SETTLE;
                    drv.sw         <= 1'b1;
                    status.dn_done <= 1'b0;
                end
                PS_UP_SETTLE: if (tmr_zero) begin
                    state          <= PS_UP_ISO;
                    drv.iso        <= 1'b0;
                    status.pwr_on  <= 1'b1;
                end
                PS_UP_ISO: if (tmr_zero) begin
                    state          <= PS_ON;
                    drv.rst        <= 1'b0;
                    status.up_done <= 1'b1;
                end
                PS_ON: if (collapse) begin
                    state          <= PS_DN_RST;
                    drv.rst        <= 1'b1;
                    status.up_done <= 1'b0;
                end
                PS_DN_RST: if (tmr_zero) begin
                    state          <= PS_DN_ISO;
                    drv.iso        <= 1'b1;
                end
                PS_DN_ISO: if (tmr_zero) begin
                    state          <= PS_OFF;
                    drv.sw         <= 1'b0;
                    status.pwr_on  <= 1'b0;
                    status.dn_done <= 1'b1;
                end
                default: state <= PS_OFF;
            endcase
            // a fresh request outranks a completion on the same edge
            if (req.wr && req.val)  status.up_done <= 1'b0;
            if (req.wr && !req.val) status.dn_done <= 1'b0;
        end
    end

    // cycles spent inside a transition, saturating
    logic [LIM_W-1:0] busy_cnt;
    always_ff @(posedge clk) begin
        if (rst || is_steady(state)) begin
            busy_cnt <= '0;
        end else if (busy_cnt != LIM_W'(LIMIT_CYC)) begin
            busy_cnt <= busy_cnt + 1'b1;
        end
    end

    AST_SEQ_BOUND: assert property (@(posedge clk) disable iff (rst)
        busy_cnt < LIM_W'(LIMIT_CYC)); // R8
    AST_ISO_WHEN_OPEN: assert property (@(posedge clk) disable iff (rst)
        !drv.sw |-> drv.iso); // R9
    AST_RST_WHEN_ISO: assert property (@(posedge clk) disable iff (rst)
        drv.iso |-> drv.rst); // R9
    AST_FLAGS_EXCL: assert property (@(posedge clk) disable iff (rst)
        !(status.up_done && status.dn_done)); // R6
    AST_PWR_NEEDS_SW: assert property (@(posedge clk) disable iff (rst)
        status.pwr_on |-> drv.sw); // R4
    AST_UP_DONE_LIVE: assert property (@(posedge clk) disable iff (rst)
        $rose(status.up_done) |-> (!drv.rst && !drv.iso)); // R4
    AST_DN_DONE_DARK: assert property (@(posedge clk) disable iff (rst)
        $rose(status.dn_done) |-> (!drv.sw && !status.pwr_on)); // R5

endmodule

// File: rtl/pwr_dom_seq.sv
module pwr_dom_seq
    import pds_pkg::*;
#(
    parameter int ADDR_W     = 4,
    parameter int CLK_MHZ    = 50,
    parameter int LIMIT_US   = 1500,
    parameter int SETTLE_CYC = 16,
    parameter int STEP_CYC   = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [31:0]       wdata,
    output logic [31:0]       rdata,
    output logic              sw_en,
    output logic              iso_en,
    output logic              dom_rst
);
    localparam int LIMIT_CYC = LIMIT_US * CLK_MHZ;
    localparam int MAX_WAIT  = (SETTLE_CYC > STEP_CYC) ? SETTLE_CYC : STEP_CYC;
    localparam int TMR_W     = $clog2(MAX_WAIT + 1);

    logic             collapse;
    pds_req_t         req;
    pds_status_t      status;
    pds_drive_t       drv;
    logic             tmr_load;
    logic             tmr_zero;
    logic [TMR_W-1:0] tmr_val;

    pds_regs #(.ADDR_W(ADDR_W)) u_regs (
        .clk      (clk),
        .rst      (rst),
        .wr_en    (wr_en),
        .addr     (addr),
        .wdata    (wdata),
        .status   (status),
        .collapse (collapse),
        .req      (req),
        .rdata    (rdata)
    );

    pds_timer #(.W(TMR_W)) u_timer (
        .clk      (clk),
        .rst      (rst),
        .load     (tmr_load),
        .load_val (tmr_val),
        .zero     (tmr_zero)
    );

    pds_fsm #(
        .SETTLE_CYC (SETTLE_CYC),
        .STEP_CYC   (STEP_CYC),
        .LIMIT_CYC  (LIMIT_CYC),
        .TMR_W      (TMR_W)
    ) u_fsm (
        .clk      (clk),
        .rst      (rst),
        .collapse (collapse),
        .req      (req),
        .tmr_zero (tmr_zero),
        .tmr_load (tmr_load),
        .tmr_val  (tmr_val),
        .drv      (drv),
        .status   (status)
    );

    assign sw_en   = drv.sw;
    assign iso_en  = drv.iso;
    assign dom_rst = drv.rst;

endmodule

// File: tb/sim_pwr_dom_seq.sv
`timescale 1ns/1ps
module sim_pwr_dom_seq;
    localparam int SET = 16;
    localparam int STP = 4;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        wr_en = 1'b0;
    logic [3:0]  addr = 4'd0;
    logic [31:0] wdata = 32'd0;
    logic [31:0] rdata;
    logic        sw_en, iso_en, dom_rst;

    int vectors = 0;
    int errors  = 0;
    bit started = 0;

    always #10 clk = ~clk;

    pwr_dom_seq #(.SETTLE_CYC(SET), .STEP_CYC(STP)) u0 (
        .clk(clk), .rst(rst), .wr_en(wr_en), .addr(addr), .wdata(wdata),
        .rdata(rdata), .sw_en(sw_en), .iso_en(iso_en), .dom_rst(dom_rst)
    );

    // behavioural reference: direction (0 idle, 1 up, 2 down) and elapsed cycles
    int m_dir, m_t;
    bit m_on, m_col, m_up, m_dn;

    always @(posedge clk) begin
        started = 1;
        if (rst) begin
            m_dir = 0; m_t = 0; m_on = 0; m_col = 1; m_up = 0; m_dn = 1; // R1
        end else begin
            if (m_dir == 0) begin
                if (!m_on && !m_col) begin m_dir = 1; m_t = 0; m_dn = 0; end      // R4
                else if (m_on && m_col) begin m_dir = 2; m_t = 0; m_up = 0; end  // R5, R7
            end else begin
                m_t++;
                if (m_dir == 1 && m_t == SET + STP) begin m_dir = 0; m_on = 1; m_up = 1; end
                if (m_dir == 2 && m_t == 2 * STP)   begin m_dir = 0; m_on = 0; m_dn = 1; end
            end
            if (wr_en && addr[3:2] == 2'd0) begin // R2, R6: clear wins
                m_col = wdata[0];
                if (wdata[0]) m_up = 0; else m_dn = 0;
            end
        end
    end

    task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
        vectors++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s got %h expected %h at %0t", tag, got, exp, $time);
        end
    endtask

    function automatic logic [31:0] exp_rdata(input logic [3:0] a);
        logic [31:0] s;
        bit pw;
        pw = (m_dir == 1) ? (m_t >= SET) : (m_dir == 2) ? 1'b1 : m_on;
        s = 32'd0;
        s[15] = m_dn; s[16] = m_up; s[31] = pw;
        case (a[3:2])
            2'd0:    return {31'd0, m_col};
            2'd1:    return s;           // R3
            default: return 32'd0;
        endcase
    endfunction

    always @(negedge clk) begin
        bit es, ei, er;
        if (started) begin
            if (m_dir == 1)      begin es = 1; ei = (m_t < SET); er = 1; end
            else if (m_dir == 2) begin es = 1; ei = (m_t >= STP); er = 1; end
            else                 begin es = m_on; ei = !m_on; er = !m_on; end
            chk("R4/R5 sw_en",  {31'd0, sw_en},  {31'd0, es});
            chk("R9 iso_en",    {31'd0, iso_en}, {31'd0, ei});
            chk("R5 dom_rst",   {31'd0, dom_rst},{31'd0, er});
            chk("R3/R6 rdata",  rdata, exp_rdata(addr));
        end
    end

    task automatic step(input logic w, input logic [3:0] a, input logic [31:0] d);
        @(posedge clk); #2;
        wr_en = w; addr = a; wdata = d;
    endtask

    task automatic idle(input int n, input logic [3:0] a);
        for (int i = 0; i < n; i++) step(1'b0, a, 32'd0);
    endtask

    task automatic finish_run();
        $display("  == %0d vectors applied, %0d miscompares ==", vectors, errors);
        $finish;
    endtask

    initial begin
        #(200000 * 20);
        errors++;
        $display("FAIL watchdog R8 expired, got hang expected finish");
        finish_run();
    end

    initial begin
        repeat (3) @(posedge clk);
        #2 rst = 1'b0;
        #6 chk("R1 status after reset", rdata, 32'h0000_0001);
        addr = 4'h4;
        #1 chk("R1 status after reset", rdata, 32'h0000_8000);
        idle(3, 4'h4);
        step(1'b1, 4'h0, 32'h0);            // R4 power up
        idle(SET + STP + 5, 4'h4);
        step(1'b1, 4'h0, 32'hFFFF_FFF1);    // R5 down, junk upper bits (R2)
        idle(2, 4'h0);
        idle(2 * STP + 4, 4'h4);
        step(1'b1, 4'h4, 32'h0);            // R3 status write ignored
        step(1'b1, 4'h8, 32'h0);            // R3 other word ignored
        step(1'b1, 4'hF, 32'h0);
        idle(4, 4'hC);
        step(1'b1, 4'h1, 32'h0);            // R3 low address bits ignored -> up
        idle(5, 4'h4);
        step(1'b1, 4'h0, 32'h1);            // R7 reverse mid-sequence
        idle(SET + 3 * STP + 6, 4'h4);
        step(1'b1, 4'h0, 32'h0);            // R6 same-edge collision
        idle(SET + STP, 4'h4);
        step(1'b1, 4'h0, 32'h1);
        idle(2 * STP + 6, 4'h4);
        step(1'b1, 4'h0, 32'h1);            // R7 repeated request: no sequence
        idle(4, 4'h4);
        step(1'b1, 4'h0, 32'h0);
        idle(3, 4'h4);
        step(1'b1, 4'h0, 32'h0);            // R7 repeat during up
        idle(SET + STP + 4, 4'h4);
        step(1'b1, 4'h0, 32'h0);            // R6 write 0 while on
        idle(3, 4'h4);
        idle(2, 4'h0);
        step(1'b0, 4'h4, 32'h0);
        // R8: every transition above completes well inside the window
        idle(2, 4'h4);
        finish_run();
    end
endmodule